// File: doc/BRIEF.md
# Timer Slave Mode Controller

This block decides, cycle by cycle, whether a timer counter advances, in which direction, and on which cycles it takes a step. A 3-bit mode field selects the source of those steps. The counter can run freely under the software enable, or it can be gated by a trigger level. It can also be started by a trigger edge, or clocked by trigger edges. Three further modes decode a two-phase rotary encoder. In those modes the count follows edges on phase A only, on phase B only, or on both phases, which gives four counts per encoder cycle.

A trigger-select field picks one of several internal trigger lines. All trigger and encoder inputs pass through two-flop synchronisers before edge detection. A small wrap-around counter with a programmable reload value is included, so the step, run and direction outputs can be observed as a count.

Top module: `tmr_slave_ctl`

## Requirements
- R1: While reset is held and after it is released, the count is 0 and step_o and dir_o are 0 until a counting condition occurs.
- R2: Mode 0 (free): count_o changes by one on each cycle where en_i is high. It goes down when dir_down_i is 1 and up when dir_down_i is 0, and dir_o equals dir_down_i.
- R3: The counter wraps in both directions. An up step from the reload value gives 0, and a down step from 0 gives the reload value.
- R4: Mode 5 (gated): with en_i high, the count rises once per cycle while the synchronised selected trigger is high. It holds its value, without resetting, while that trigger is low.
- R5: trig_sel_i is an index into trig_i. Only the trigger line at that index affects counting, and the other lines are ignored.
- R6: Mode 6 (triggered): a rising edge of the selected trigger sets an internal run flag. The count then rises every cycle, whatever en_i or the trigger level does after that, and run_o is 1. The run flag clears whenever the mode field is not 6.
- R7: Mode 7 (trigger clock): with en_i high, the count rises exactly once per rising edge of the selected trigger.
- R8: Mode 1: the count changes only on phase A edges, twice per encoder cycle. It goes up when A leads B, that is when A differs from B after an A edge.
- R9: Mode 2: the count changes only on phase B edges, twice per encoder cycle. It goes up when B equals A after a B edge.
- R10: Mode 3: the count changes on every A and B edge, four times per encoder cycle, up when A leads B and down when B leads A.
- R11: In modes 1 to 3, dir_o holds the direction of the last counted edge, with 1 meaning down.
- R12: An encoder input change first shows in count_o after exactly three rising clock edges, two of which are synchroniser flops.
- R13: With en_i low, modes 0, 1, 2, 3, 5 and 7 never step. Mode 4 is reserved and never steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Software counter enable |
| mode_i | input | 3 | Slave mode field |
| trig_sel_i | input | SEL_W | Trigger line index |
| trig_i | input | NUM_TRIG | Internal trigger lines, asynchronous |
| enc_a_i | input | 1 | Encoder phase A, asynchronous |
| enc_b_i | input | 1 | Encoder phase B, asynchronous |
| reload_i | input | CNT_W | Reload (top) value of the counter |
| dir_down_i | input | 1 | Software direction for non-encoder modes, 1 = down |
| count_o | output | CNT_W | Counter value |
| step_o | output | 1 | Count pulse for this cycle |
| run_o | output | 1 | Count enable in effect |
| dir_o | output | 1 | Count direction, 1 = down |

## Verification
Each encoder mode is driven through whole quadrature cycles, first in forward order and then in reverse order. The counts for the same motion differ by mode: twice per cycle for one phase and four times for both. This separates the three decoders, and the reverse runs confirm the phase-order direction rule and the wrap at both ends. The gated and trigger-clock modes are swept over every trigger index, with all the other lines toggling, which tells selection apart from simple OR-ing of the lines. A single-edge latency probe pins the synchroniser depth. The triggered-mode run proves that the flag persists after the trigger pulse and that a mode change clears it.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

   typedef enum logic [2:0] {
      SM_FREE   = 3'd0,
      SM_ENC_A  = 3'd1,
      SM_ENC_B  = 3'd2,
      SM_ENC_AB = 3'd3,
      SM_RSVD   = 3'd4,
      SM_GATED  = 3'd5,
      SM_TRIG   = 3'd6,
      SM_EXTCLK = 3'd7
   } tsc_mode_e;

   function automatic logic is_encoder(input tsc_mode_e m);
      return (m == SM_ENC_A) || (m == SM_ENC_B) || (m == SM_ENC_AB);
   endfunction

endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tsc_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     stage_q[s] <= '0;
         else if (s == 0) stage_q[s] <= d_i;
         else             stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/tsc_quad_dec.sv
module tsc_quad_dec
   import tsc_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      a_i,
   input  logic      b_i,
   input  tsc_mode_e mode_i,
   output logic      edge_o,
   output logic      down_o
);

   logic a_q, b_q;
   logic a_ev, b_ev;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         a_q <= 1'b0;
         b_q <= 1'b0;
      end else begin
         a_q <= a_i;
         b_q <= b_i;
      end
   end

   assign a_ev = a_i ^ a_q;
   assign b_ev = b_i ^ b_q;

   always_comb begin
      edge_o = 1'b0;
      down_o = 1'b0;
      unique case (mode_i)
         SM_ENC_A: begin
            edge_o = a_ev;
            down_o = (a_i == b_i);
         end
         SM_ENC_B: begin
            edge_o = b_ev;
            down_o = (a_i != b_i);
         end
         SM_ENC_AB: begin
            edge_o = a_ev ^ b_ev;
            down_o = a_ev ? (a_i == b_i) : (a_i != b_i);
         end
         default: begin
            edge_o = 1'b0;
            down_o = 1'b0;
         end
      endcase
   end

   // R10
   ab_single_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == SM_ENC_AB && edge_o) |-> ($past(a_i) != a_i) != ($past(b_i) != b_i));

endmodule

// File: rtl/tsc_counter.sv
module tsc_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             step_i,
   input  logic             down_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] count_o
);

   if (CNT_W < 2) begin : g_bad_width
      $error("tsc_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] count_q, count_d;

   always_comb begin
      count_d = count_q;
      if (step_i) begin
         if (down_i) count_d = (count_q == '0) ? reload_i : count_q - 1'b1;
         else        count_d = (count_q >= reload_i) ? '0 : count_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) count_q <= '0;
      else         count_q <= count_d;
   end

   assign count_o = count_q;

   // R3
   wrap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !down_i && count_q >= reload_i) |=> count_q == '0);

   // R3
   wrap_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && down_i && count_q == '0) |=> count_q == $past(reload_i));

   // R4
   hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !step_i |=> $stable(count_q));

endmodule

// File: rtl/tmr_slave_ctl.sv
module tmr_slave_ctl
   import tsc_pkg::*;
#(
   parameter  int CNT_W       = 8,
   parameter  int NUM_TRIG    = 4,
   parameter  int SYNC_STAGES = 2,
   localparam int SEL_W       = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                en_i,
   input  logic [2:0]          mode_i,
   input  logic [SEL_W-1:0]    trig_sel_i,
   input  logic [NUM_TRIG-1:0] trig_i,
   input  logic                enc_a_i,
   input  logic                enc_b_i,
   input  logic [CNT_W-1:0]    reload_i,
   input  logic                dir_down_i,
   output logic [CNT_W-1:0]    count_o,
   output logic                step_o,
   output logic                run_o,
   output logic                dir_o
);

   if (NUM_TRIG < 1 || NUM_TRIG > 16) begin : g_bad_trig
      $error("tmr_slave_ctl: NUM_TRIG must be within 1..16");
   end

   localparam int SYNC_W = NUM_TRIG + 2;

   tsc_mode_e          mode;
   logic [SYNC_W-1:0]  sync_q;
   logic [NUM_TRIG-1:0] trig_s;
   logic               a_s, b_s;
   logic               trg, trg_q, trg_rise;
   logic               started_q;
   logic               enc_edge, enc_down, enc_dir_q;
   logic               step, down;

   assign mode = tsc_mode_e'(mode_i);

   tsc_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   ({enc_b_i, enc_a_i, trig_i}),
      .q_o   (sync_q)
   );

   assign trig_s = sync_q[NUM_TRIG-1:0];
   assign a_s    = sync_q[NUM_TRIG];
   assign b_s    = sync_q[NUM_TRIG+1];

   always_comb begin
      trg = 1'b0;
      for (int i = 0; i < NUM_TRIG; i++)
         if (trig_sel_i == SEL_W'(i)) trg = trig_s[i];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) trg_q <= 1'b0;
      else         trg_q <= trg;
   end

   assign trg_rise = trg & ~trg_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              started_q <= 1'b0;
      else if (mode != SM_TRIG) started_q <= 1'b0;
      else if (trg_rise)        started_q <= 1'b1;
   end

   tsc_quad_dec u_dec (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .a_i   (a_s),
      .b_i   (b_s),
      .mode_i(mode),
      .edge_o(enc_edge),
      .down_o(enc_down)
   );

   always_comb begin
      run_o = 1'b0;
      step  = 1'b0;
      unique case (mode)
         SM_FREE: begin
            run_o = en_i;
            step  = en_i;
         end
         SM_ENC_A, SM_ENC_B, SM_ENC_AB: begin
            run_o = en_i;
            step  = en_i & enc_edge;
         end
         SM_GATED: begin
            run_o = en_i & trg;
            step  = en_i & trg;
         end
         SM_TRIG: begin
            run_o = en_i | started_q;
            step  = en_i | started_q;
         end
         SM_EXTCLK: begin
            run_o = en_i;
            step  = en_i & trg_rise;
         end
         default: begin
            run_o = 1'b0;
            step  = 1'b0;
         end
      endcase
   end

   assign down = is_encoder(mode) ? enc_down : dir_down_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     enc_dir_q <= 1'b0;
      else if (step && is_encoder(mode)) enc_dir_q <= enc_down;
   end

   assign dir_o  = is_encoder(mode) ? enc_dir_q : dir_down_i;
   assign step_o = step;

   tsc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (step),
      .down_i  (down),
      .reload_i(reload_i),
      .count_o (count_o)
   );

   // R6
   started_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (started_q && mode == SM_TRIG) |=> started_q);

   // R7
   extclk_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == SM_EXTCLK && step_o) |=> (mode != SM_EXTCLK || !step_o));

   // R13
   reserved_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == SM_RSVD) |-> !step_o && !run_o);

endmodule

// File: tb/tmr_slave_ctl_bench.sv
module tmr_slave_ctl_bench;

   localparam int CW = 8;
   localparam int NT = 4;
   localparam int RL = 10;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          en;
   logic [2:0]    mode;
   logic [1:0]    sel;
   logic [NT-1:0] trig;
   logic          enc_a, enc_b;
   logic [CW-1:0] reload;
   logic          dir_dn;
   logic [CW-1:0] count;
   logic          step, run, dir;

   int errors = 0;
   int checks = 0;
   int phase  = 0;

   always #4 clk = ~clk;

   tmr_slave_ctl #(.CNT_W(CW), .NUM_TRIG(NT), .SYNC_STAGES(2)) u_tmr_slave_ctl (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .trig_sel_i(sel),
      .trig_i(trig), .enc_a_i(enc_a), .enc_b_i(enc_b), .reload_i(reload),
      .dir_down_i(dir_dn), .count_o(count), .step_o(step), .run_o(run), .dir_o(dir)
   );

   function automatic int wrapv(int v);
      return ((v % (RL + 1)) + (RL + 1)) % (RL + 1);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [2:0] m);
      @(negedge clk);
      rst_n = 1'b0; en = 1'b0; mode = m; sel = 2'd0; trig = '0;
      enc_a = 1'b0; enc_b = 1'b0; reload = CW'(RL); dir_dn = 1'b0; phase = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic set_phase();
      enc_a = (phase == 1) || (phase == 2);
      enc_b = (phase == 2) || (phase == 3);
   endtask

   task automatic quad_move(input int cycles, input bit rev);
      for (int i = 0; i < 4 * cycles; i++) begin
         @(negedge clk);
         phase = rev ? (phase + 3) % 4 : (phase + 1) % 4;
         set_phase();
         repeat (3) @(negedge clk);
      end
      repeat (6) @(negedge clk);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int c1;
      // R1 reset state
      do_reset(3'd4);
      check(count == 0 && step == 0 && dir == 0, "R1", int'(count), 0);

      // R2 free mode up, then R3 wrap up
      do_reset(3'd0);
      check(count == 0 && step == 0, "R1", int'(step), 0);
      en = 1'b1; wait_cyc(7); en = 1'b0; wait_cyc(3);
      check(count == CW'(7), "R2", int'(count), 7);
      check(dir == 1'b0, "R11", int'(dir), 0);
      dir_dn = 1'b1; en = 1'b1; wait_cyc(9); en = 1'b0; wait_cyc(3);
      check(count == CW'(wrapv(-2)), "R3", int'(count), wrapv(-2));
      check(dir == 1'b1, "R11", int'(dir), 1);
      dir_dn = 1'b0; en = 1'b1; wait_cyc(15); en = 1'b0; wait_cyc(3);
      check(count == CW'(wrapv(wrapv(-2) + 15)), "R3", int'(count), wrapv(wrapv(-2) + 15));

      // R4 / R5 gated sweep over every trigger index
      for (int s = 0; s < NT; s++) begin
         do_reset(3'd5);
         sel = 2'(s); en = 1'b1;
         for (int k = 0; k < 12; k++) begin
            trig = ~(NT'(1) << s) & NT'(k % 2 == 0 ? 4'hF : 4'h5);
            @(negedge clk);
         end
         trig = '0; wait_cyc(4);
         check(count == 0, "R5", int'(count), 0);
         trig = NT'(1) << s; wait_cyc(5 + s); trig = '0; wait_cyc(5);
         check(count == CW'(5 + s), "R4", int'(count), 5 + s);
         wait_cyc(10);
         check(count == CW'(5 + s), "R4", int'(count), 5 + s);
      end

      // R7 / R5 trigger clock sweep, R13 with enable low
      for (int s = 0; s < NT; s++) begin
         do_reset(3'd7);
         sel = 2'(s);
         for (int k = 0; k < 4; k++) begin
            trig = NT'(1) << s; wait_cyc(3); trig = '0; wait_cyc(3);
         end
         check(count == 0, "R13", int'(count), 0);
         en = 1'b1;
         for (int k = 0; k < 13; k++) begin
            trig = ~(NT'(1) << s); wait_cyc(3); trig = '0; wait_cyc(3);
         end
         check(count == 0, "R5", int'(count), 0);
         for (int k = 0; k < 13; k++) begin
            trig = NT'(1) << s; wait_cyc(3); trig = '0; wait_cyc(3);
         end
         wait_cyc(4);
         check(count == CW'(wrapv(13)), "R7", int'(count), wrapv(13));
      end

      // R6 triggered mode
      do_reset(3'd6);
      sel = 2'd1; wait_cyc(10);
      check(count == 0 && run == 0, "R6", int'(count), 0);
      trig = 4'b0010; wait_cyc(1); trig = '0; wait_cyc(8);
      c1 = int'(count);
      wait_cyc(5);
      check(count == CW'(wrapv(c1 + 5)), "R6", int'(count), wrapv(c1 + 5));
      check(run == 1'b1, "R6", int'(run), 1);
      mode = 3'd0; wait_cyc(2);
      c1 = int'(count);
      wait_cyc(5);
      check(count == CW'(c1) && run == 0, "R6", int'(count), c1);
      mode = 3'd6; wait_cyc(5);
      check(count == CW'(c1) && run == 0, "R6", int'(count), c1);

      // R12 latency
      do_reset(3'd3);
      en = 1'b1;
      @(negedge clk); phase = 1; set_phase();
      @(posedge clk); @(posedge clk); #1;
      check(count == 0, "R12", int'(count), 0);
      @(posedge clk); #1;
      check(count == 1, "R12", int'(count), 1);

      // R8 R9 R10 R11 encoder sweep, both directions
      for (int m = 1; m <= 3; m++) begin
         int per;
         per = (m == 3) ? 4 : 2;
         do_reset(3'(m));
         en = 1'b1;
         quad_move(3, 1'b0);
         check(count == CW'(wrapv(3 * per)),
               (m == 1) ? "R8" : (m == 2) ? "R9" : "R10", int'(count), wrapv(3 * per));
         check(dir == 1'b0, "R11", int'(dir), 0);
         quad_move(5, 1'b1);
         check(count == CW'(wrapv(-2 * per)),
               (m == 1) ? "R8" : (m == 2) ? "R9" : "R10", int'(count), wrapv(-2 * per));
         check(dir == 1'b1, "R11", int'(dir), 1);
         // R13 enable low blocks encoder counting
         en = 1'b0;
         quad_move(2, 1'b0);
         check(count == CW'(wrapv(-2 * per)), "R13", int'(count), wrapv(-2 * per));
      end

      // R13 reserved mode
      do_reset(3'd4);
      en = 1'b1; trig = '1;
      quad_move(2, 1'b0);
      check(count == 0, "R13", int'(count), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule